// File: doc/BRIEF.md
# Keyed Software Reset and Watchdog Controller

This block sits on a simple register write port (write enable, address, data byte) and does two jobs. First, it guards a chip-wide software reset: the reset command register refuses writes until firmware has stored the bytes 55h, AAh and 5Ah, in that order, into a key register. The correct sequence opens a short write window. A command written inside that window drives the system reset output for a fixed number of cycles. That output is meant to reset the whole chip, not just the processor.

Second, it runs a watchdog with an 8-bit counter. The counter advances on a tick taken from a free-running prescaler. A 4-bit mode value selects which power-of-two tap of the prescaler produces the tick. Firmware restarts the count by writing the key value 55h to a refresh register. On timeout the watchdog either latches an interrupt flag or requests a system reset. A watchdog-initiated reset sets a sticky status flag. Only power-on reset or a software clear removes that flag.

The block has two reset inputs. `por_n` is the power-on reset; it alone clears the reset pulse generator and the sticky flag. `rst_n` is the chip reset domain, which the surrounding logic drives low while `sys_rst_o` is high. The key state machine, watchdog and interrupt flag live in that domain.

The key state machine has four states. In KEY_IDLE it waits for a first key. KEY_GOT1 follows a 55h key write, and KEY_GOT2 follows an AAh key write. KEY_OPEN is the window state. Its transitions are:
- KEY_IDLE to KEY_GOT1 on 55h at the key address.
- KEY_GOT1 to KEY_GOT2 on AAh at the key address.
- KEY_GOT2 to KEY_OPEN on 5Ah at the key address.
- KEY_GOT1 and KEY_GOT2 return to KEY_IDLE on any other write.
- KEY_OPEN returns to KEY_IDLE on a write to the command register, or when the window count expires.

The pulse generator has two states. It moves from PG_IDLE to PG_HOLD on a reset request. It returns from PG_HOLD to PG_IDLE after RST_LEN cycles.

Top module: `rstwdt_ctrl`

## Requirements
- R1: After power-on reset, sys_rst_o, swr_window_o, wdt_irq_o and wdt_rst_flag_o are all low.
- R2: swr_window_o rises in the cycle after the third of three writes to the key address (default 10h) carrying 55h, AAh and 5Ah in that order, with no other write in between.
- R3: Any write that does not continue the key sequence returns the sequence to its start. This covers a wrong value at the key address and a write to any other address. The whole sequence must then be written again from 55h.
- R4: The window closes after the first write to the command address (default 11h), or after WIN_CYC cycles without such a write. A write to the command address while the window is closed has no effect.
- R5: A write to the command address inside the window with data bit 0 set drives sys_rst_o high from the next cycle for RST_LEN cycles. With bit 0 clear, no reset occurs.
- R6: The watchdog configuration register (default 12h) holds the mode in bits 3:0, the enable in bit 4 and the action in bit 5 (0 = interrupt, 1 = reset). When the watchdog is enabled, it times out 256·2^mode cycles after the enabling write or the last refresh.
- R7: Writing 55h to the refresh address (default 13h) restarts the timeout interval. Any other value written there has no effect.
- R8: A timeout with action 0 sets wdt_irq_o. Writing the status address (default 14h) with bit 0 set clears it. Counting continues after the timeout.
- R9: A timeout with action 1 drives sys_rst_o high for RST_LEN cycles and sets wdt_rst_flag_o.
- R10: wdt_rst_flag_o keeps its value through the system reset. Only a status write with bit 1 set, or power-on reset, clears it.
- R11: A system reset returns the key sequence to its start, disables the watchdog and clears wdt_irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Asynchronous chip-domain reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| sys_rst_o | output | 1 | Chip-wide reset request pulse |
| swr_window_o | output | 1 | Command register write window open |
| wdt_irq_o | output | 1 | Watchdog interrupt flag |
| wdt_rst_flag_o | output | 1 | Sticky watchdog-reset status flag |

## Verification
The bench targets several sequences that a loose design would mishandle:
- Key sequences broken by a wrong key value or by a write to an unrelated address. A design that only checks the last key, or ignores foreign writes, would open the window.
- A command written after the window has timed out. A window that never times out would let it reset the chip.
- A command with bit 0 clear. A design that treats any write as the command would reset.
- A wrong refresh value. A design that refreshes on any write would never time out.

It also measures the exact timeout cycle in two modes, so an off-by-one tap choice shows up. It then lets a watchdog reset go through and checks two things: the flag must survive the reset, and the configuration and interrupt flag must not survive it.

// File: rtl/rstwdt_pkg.sv
package rstwdt_pkg;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_GOT1,
        KEY_GOT2,
        KEY_OPEN
    } key_state_t;

    typedef enum logic {
        PG_IDLE,
        PG_HOLD
    } pulse_state_t;

    localparam int MODE_W = 4;

    typedef struct packed {
        logic              act;
        logic              en;
        logic [MODE_W-1:0] mode;
    } wd_cfg_t;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [7:0] KEY_THIRD  = 8'h5A;
    localparam logic [7:0] WD_REFRESH = 8'h55;

endpackage

// File: rtl/rstwdt_unlock.sv
module rstwdt_unlock
    import rstwdt_pkg::*;
#(
    parameter int WIN_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       key_hit,
    input  logic       cmd_hit,
    input  logic [7:0] wr_data,
    output logic       window_o,
    output logic       sw_req_o
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

    key_state_t       state_q, state_d;
    logic [WIN_W-1:0] win_cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: begin
                if (key_hit && wr_data == KEY_FIRST) begin
                    state_d = KEY_GOT1;
                end
            end
            KEY_GOT1: begin
                if (wr_en) begin
                    state_d = (key_hit && wr_data == KEY_SECOND) ? KEY_GOT2 : KEY_IDLE;
                end
            end
            KEY_GOT2: begin
                if (wr_en) begin
                    state_d = (key_hit && wr_data == KEY_THIRD) ? KEY_OPEN : KEY_IDLE;
                end
            end
            KEY_OPEN: begin
                if (cmd_hit || win_cnt_q == WIN_LAST) begin
                    state_d = KEY_IDLE;
                end
            end
            default: state_d = KEY_IDLE;
        endcase
    end

    // window lifetime counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
        end else if (state_q != KEY_OPEN) begin
            win_cnt_q <= '0;
        end else begin
            win_cnt_q <= win_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        window_o = (state_q == KEY_OPEN);
        sw_req_o = (state_q == KEY_OPEN) && cmd_hit && wr_data[0];
    end

endmodule

// File: rtl/rstwdt_wdog.sv
module rstwdt_wdog
    import rstwdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  wd_cfg_t    cfg_data,
    input  logic       kick_we,
    input  logic [7:0] kick_data,
    input  logic       clr_irq,
    output logic       irq_o,
    output logic       rst_req_o
);

    localparam int PRE_W = (2 ** MODE_W) - 1;
    localparam logic [PRE_W-1:0]  PRE_ONES = {PRE_W{1'b1}};
    localparam logic [MODE_W-1:0] PRE_TOP  = MODE_W'(PRE_W);
    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};

    wd_cfg_t          cfg_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] tap_mask;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             tick;
    logic             expire;

    assign restart  = (kick_we && kick_data == WD_REFRESH) || cfg_we;
    assign tap_mask = PRE_ONES >> (PRE_TOP - cfg_q.mode);
    assign tick     = cfg_q.en && ((pre_q & tap_mask) == tap_mask);
    assign expire   = tick && (cnt_q == CNT_MAX) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (restart || !cfg_q.en) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (expire && !cfg_q.act) begin
            irq_o <= 1'b1;
        end else if (clr_irq) begin
            irq_o <= 1'b0;
        end
    end

    assign rst_req_o = expire && cfg_q.act;

endmodule

// File: rtl/rstwdt_pulse.sv
module rstwdt_pulse
    import rstwdt_pkg::*;
#(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic sw_req,
    input  logic wd_req,
    input  logic clr_flag,
    output logic sys_rst_o,
    output logic flag_o
);

    localparam int CW = $clog2(RST_LEN + 1);
    localparam logic [CW-1:0] LEN_LAST = CW'(RST_LEN - 1);

    pulse_state_t state_q, state_d;
    logic [CW-1:0] len_q;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= PG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE: if (sw_req || wd_req) state_d = PG_HOLD;
            PG_HOLD: if (len_q == LEN_LAST) state_d = PG_IDLE;
            default: state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            len_q <= '0;
        end else if (state_q == PG_HOLD) begin
            len_q <= len_q + 1'b1;
        end else begin
            len_q <= '0;
        end
    end

    // sticky watchdog-reset flag, power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_o <= 1'b0;
        end else if (wd_req && state_q == PG_IDLE) begin
            flag_o <= 1'b1;
        end else if (clr_flag) begin
            flag_o <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        sys_rst_o = (state_q == PG_HOLD);
    end

endmodule

// File: rtl/rstwdt_ctrl.sv
module rstwdt_ctrl
    import rstwdt_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h10,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h11,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h12,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 8'h13,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h14,
    parameter int              WIN_CYC   = 64,
    parameter int              RST_LEN   = 4,
    parameter int              WD_CNT_W  = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              sys_rst_o,
    output logic              swr_window_o,
    output logic              wdt_irq_o,
    output logic              wdt_rst_flag_o
);

    logic key_hit, cmd_hit, cfg_hit, kick_hit, stat_hit;
    logic sw_req, wd_req;

    assign key_hit  = wr_en && (wr_addr == KEY_ADDR);
    assign cmd_hit  = wr_en && (wr_addr == CMD_ADDR);
    assign cfg_hit  = wr_en && (wr_addr == CFG_ADDR);
    assign kick_hit = wr_en && (wr_addr == KICK_ADDR);
    assign stat_hit = wr_en && (wr_addr == STAT_ADDR);

    rstwdt_unlock #(
        .WIN_CYC (WIN_CYC)
    ) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .key_hit  (key_hit),
        .cmd_hit  (cmd_hit),
        .wr_data  (wr_data),
        .window_o (swr_window_o),
        .sw_req_o (sw_req)
    );

    rstwdt_wdog #(
        .CNT_W (WD_CNT_W)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_hit),
        .cfg_data  (wd_cfg_t'(wr_data[5:0])),
        .kick_we   (kick_hit),
        .kick_data (wr_data),
        .clr_irq   (stat_hit && wr_data[0]),
        .irq_o     (wdt_irq_o),
        .rst_req_o (wd_req)
    );

    rstwdt_pulse #(
        .RST_LEN (RST_LEN)
    ) u_pulse (
        .clk       (clk),
        .por_n     (por_n),
        .sw_req    (sw_req),
        .wd_req    (wd_req),
        .clr_flag  (stat_hit && wr_data[1]),
        .sys_rst_o (sys_rst_o),
        .flag_o    (wdt_rst_flag_o)
    );

endmodule

// File: rtl/rstwdt_ctrl_chk.sv
module rstwdt_ctrl_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h10,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h11,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h14
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              sys_rst_o,
    input logic              swr_window_o,
    input logic              wdt_irq_o,
    input logic              wdt_rst_flag_o
);

    // R2: the window only opens right after the final key byte
    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swr_window_o) |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == 8'h5A));

    // R4: a command write always closes the window
    a_r4_window_shuts: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && swr_window_o && wr_en && wr_addr == CMD_ADDR) |=> !swr_window_o);

    // R5: a command with bit 0 set inside the window starts the reset pulse
    a_r5_cmd_pulses: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && swr_window_o && wr_en && wr_addr == CMD_ADDR && wr_data[0]) |=> sys_rst_o);

    // R8: the interrupt flag only drops on a status write
    a_r8_irq_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_irq_o) |-> $past(wr_en && wr_addr == STAT_ADDR && wr_data[0]));

    // R9: the sticky flag only rises together with a reset pulse
    a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wdt_rst_flag_o) |-> $rose(sys_rst_o));

    // R10: the sticky flag only drops on a status write
    a_r10_flag_cleared_by_write: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wdt_rst_flag_o) |-> $past(wr_en && wr_addr == STAT_ADDR && wr_data[1]));

    // R11: chip reset holds the domain outputs low
    a_r11_quiet_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |-> (!swr_window_o && !wdt_irq_o));

endmodule

bind rstwdt_ctrl rstwdt_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .KEY_ADDR  (KEY_ADDR),
    .CMD_ADDR  (CMD_ADDR),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .sys_rst_o      (sys_rst_o),
    .swr_window_o   (swr_window_o),
    .wdt_irq_o      (wdt_irq_o),
    .wdt_rst_flag_o (wdt_rst_flag_o)
);

// File: tb/test_rstwdt_ctrl.sv
module test_rstwdt_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WIN_CYC    = 64;
    localparam int RST_LEN    = 4;
    localparam int LIMIT      = 150000;
    localparam logic [7:0] A_KEY = 8'h10, A_CMD = 8'h11, A_CFG = 8'h12,
                           A_KICK = 8'h13, A_STAT = 8'h14, A_OTHER = 8'h33;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sys_rst_o, swr_window_o, wdt_irq_o, wdt_rst_flag_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    assign rst_n = por_n && !sys_rst_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rstwdt_ctrl #(
        .WIN_CYC (WIN_CYC),
        .RST_LEN (RST_LEN)
    ) i_rstwdt_ctrl (
        .clk            (clk),
        .por_n          (por_n),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .sys_rst_o      (sys_rst_o),
        .swr_window_o   (swr_window_o),
        .wdt_irq_o      (wdt_irq_o),
        .wdt_rst_flag_o (wdt_rst_flag_o)
    );

    // behavioural reference model
    int m_step = 0;
    int m_win  = 0;
    int m_en = 0, m_mode = 0, m_act = 0;
    int m_since = 0;
    int m_irq = 0, m_flag = 0;
    int m_rst = 0, m_hold = 0;

    task automatic model_domain_reset();
        m_step = 0; m_win = 0; m_en = 0; m_mode = 0; m_act = 0;
        m_since = 0; m_irq = 0;
    endtask

    always @(posedge clk) begin
        if (!por_n) begin
            model_domain_reset();
            m_flag = 0; m_rst = 0; m_hold = 0;
        end else begin
            bit dom_reset;
            bit sw_req, wd_req, expire;
            int period;
            dom_reset = (m_rst != 0);
            sw_req = 0; wd_req = 0; expire = 0;
            if (!dom_reset) begin
                // key sequence
                if (m_step == 3) begin
                    if (wr_en && wr_addr == A_CMD) begin
                        sw_req = wr_data[0];
                        m_step = 0;
                    end else if (m_win == WIN_CYC - 1) begin
                        m_step = 0;
                    end else begin
                        m_win++;
                    end
                end else if (wr_en) begin
                    if (wr_addr == A_KEY && m_step == 0 && wr_data == 8'h55) m_step = 1;
                    else if (wr_addr == A_KEY && m_step == 1 && wr_data == 8'hAA) m_step = 2;
                    else if (wr_addr == A_KEY && m_step == 2 && wr_data == 8'h5A) begin
                        m_step = 3; m_win = 0;
                    end else m_step = 0;
                end
                // watchdog, measured in cycles since restart
                period = 256 * (1 << m_mode);
                if ((wr_en && wr_addr == A_KICK && wr_data == 8'h55) ||
                    (wr_en && wr_addr == A_CFG)) begin
                    m_since = 0;
                end else if (m_en != 0) begin
                    m_since++;
                    if (m_since % period == 0) expire = 1;
                end
                if (expire && m_act == 0) m_irq = 1;
                else if (wr_en && wr_addr == A_STAT && wr_data[0]) m_irq = 0;
                wd_req = expire && m_act != 0;
                if (wr_en && wr_addr == A_CFG) begin
                    m_mode = int'(wr_data[3:0]); m_en = int'(wr_data[4]); m_act = int'(wr_data[5]);
                end
            end
            // pulse generator and sticky flag
            if (m_rst == 0 && wd_req) m_flag = 1;
            else if (!dom_reset && wr_en && wr_addr == A_STAT && wr_data[1]) m_flag = 0;
            if (m_rst != 0) begin
                if (m_hold == RST_LEN - 1) begin m_rst = 0; m_hold = 0; end
                else m_hold++;
            end else if (sw_req || wd_req) begin
                m_rst = 1; m_hold = 0;
            end
            if (m_rst != 0) model_domain_reset();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (por_n) begin
            chk("R2/R4 window vs model", int'(swr_window_o), (m_step == 3) ? 1 : 0);
            chk("R5/R9 sys_rst vs model", int'(sys_rst_o), m_rst);
            chk("R8 irq vs model", int'(wdt_irq_o), m_irq);
            chk("R10 flag vs model", int'(wdt_rst_flag_o), m_flag);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic unlock();
        wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_KEY, 8'h5A);
    endtask

    initial begin
        idle(3);
        por_n = 1'b1;
        idle(2);
        chk("R1 sys_rst", int'(sys_rst_o), 0);
        chk("R1 window", int'(swr_window_o), 0);
        chk("R1 irq", int'(wdt_irq_o), 0);
        chk("R1 flag", int'(wdt_rst_flag_o), 0);

        // R5: software reset through the window
        unlock();
        chk("R2 window after key", int'(swr_window_o), 1);
        wr(A_CMD, 8'h01);
        chk("R5 pulse starts", int'(sys_rst_o), 1);
        idle(RST_LEN - 1);
        chk("R5 pulse still high", int'(sys_rst_o), 1);
        idle(1);
        chk("R5 pulse ended", int'(sys_rst_o), 0);
        chk("R11 window cleared", int'(swr_window_o), 0);
        idle(2);

        // R3: broken sequences
        wr(A_KEY, 8'h55); wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55); wr(A_KEY, 8'h5A);
        chk("R3 wrong value", int'(swr_window_o), 0);
        wr(A_KEY, 8'h55); wr(A_OTHER, 8'h00); wr(A_KEY, 8'hAA); wr(A_KEY, 8'h5A);
        chk("R3 foreign write", int'(swr_window_o), 0);

        // R4: window timeout, then late command ignored
        unlock();
        idle(WIN_CYC - 2);
        chk("R4 still open", int'(swr_window_o), 1);
        idle(2);
        chk("R4 timed out", int'(swr_window_o), 0);
        wr(A_CMD, 8'h01);
        chk("R4 late cmd ignored", int'(sys_rst_o), 0);

        // R5: command with bit 0 clear
        unlock();
        wr(A_CMD, 8'h00);
        chk("R5 no reset on 0", int'(sys_rst_o), 0);
        chk("R4 closed by write", int'(swr_window_o), 0);
        idle(3);
        chk("R5 still no reset", int'(sys_rst_o), 0);

        // R6/R8: mode 0 interrupt timing
        wr(A_CFG, 8'h10);
        idle(255);
        chk("R6 before timeout", int'(wdt_irq_o), 0);
        idle(1);
        chk("R8 irq at timeout", int'(wdt_irq_o), 1);
        wr(A_STAT, 8'h01);
        chk("R8 irq cleared", int'(wdt_irq_o), 0);

        // R7: refresh and wrong refresh
        wr(A_KICK, 8'h55);
        wr(A_KICK, 8'hAA);
        idle(254);
        chk("R7 wrong key no effect", int'(wdt_irq_o), 0);
        idle(1);
        chk("R7 timeout from real refresh", int'(wdt_irq_o), 1);
        wr(A_STAT, 8'h01);
        for (int k = 0; k < 3; k++) begin
            wr(A_KICK, 8'h55);
            idle(200);
        end
        chk("R7 refreshed keeps quiet", int'(wdt_irq_o), 0);

        // R6: mode 1 timing
        wr(A_CFG, 8'h11);
        idle(511);
        chk("R6 mode1 before", int'(wdt_irq_o), 0);
        idle(1);
        chk("R6 mode1 at", int'(wdt_irq_o), 1);
        wr(A_STAT, 8'h01);

        // R9/R10/R11: watchdog reset, mode 1
        wr(A_CFG, 8'h31);
        idle(511);
        chk("R9 before reset", int'(sys_rst_o), 0);
        idle(1);
        chk("R9 reset pulse", int'(sys_rst_o), 1);
        chk("R9 flag set", int'(wdt_rst_flag_o), 1);
        idle(RST_LEN + 2);
        chk("R10 flag survives", int'(wdt_rst_flag_o), 1);
        idle(600);
        chk("R11 watchdog disabled", int'(sys_rst_o) + int'(wdt_irq_o), 0);
        wr(A_STAT, 8'h01);
        chk("R10 bit0 keeps flag", int'(wdt_rst_flag_o), 1);
        wr(A_STAT, 8'h02);
        chk("R10 flag cleared", int'(wdt_rst_flag_o), 0);
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule